// File: doc/BRIEF.md
# BCD Calendar Clock with Shadow Byte Window

This block keeps the time of day and the calendar date as packed BCD values. A one-cycle pulse once per second advances a set of live counters: seconds, minutes, hours in 24-hour form, day of week, day of month, month and a two-digit year. The counters carry through month lengths of 28, 29, 30 and 31 days and handle leap years. Software cannot see the live counters. It sees eight byte-wide shadow cells at the top of a 32 KB byte address space. The cell at the lowest of those eight addresses is a control byte. The other seven hold the time fields.

The cycle after each second pulse, the shadow cells take a fresh copy of the counters. Two control bits can suspend this copy. The read-hold bit freezes the shadows so that software can read a consistent snapshot while the counters keep running. The set bit also freezes the shadows, and software may then write new field values into them. When the set bit is cleared, the counters load those values. The low six control bits hold a signed calibration value. It is stored and read back only.

An access state machine with four states governs the shadows:
- `ST_RUN`: the shadows are refreshed.
- `ST_READ`: the read-hold bit is set, and refresh is frozen.
- `ST_WRITE`: the set bit is set, and refresh is frozen.
- `ST_LOAD`: a single cycle in which the counters load from the shadows.

The transitions are:
- RUN to WRITE when the set bit is 1.
- RUN to READ when only the read-hold bit is 1.
- READ to WRITE when the set bit is 1.
- READ to RUN when the read-hold bit is 0.
- WRITE to LOAD when the set bit is 0.
- LOAD to WRITE, READ or RUN, chosen by the same priority (set bit first, then read-hold bit).

Top module: `rtc_calendar_top`

## Requirements
- R1: Seconds and minutes count 00..59 in BCD. Hours count 00..23 in BCD. 59 seconds carries into minutes, 59 minutes carries into hours, and 23:59:59 followed by one pulse gives 00:00:00 and advances the day.
- R2: On each day advance, the day of week (byte at 0x7FFC) counts 1..7, and 7 wraps to 1.
- R3: The day of month wraps to 01 after 30 for months 04, 06, 09 and 11, and after 31 for the other months. For month 02 it wraps after 29 when the BCD year is a multiple of four, and after 28 otherwise.
- R4: After 31 December 23:59:59, the next pulse gives 00:00:00 on month 01, day 01, with the year incremented. Year 99 wraps to 00.
- R5: Address map: 0x7FF8 control, 0x7FF9 seconds, 0x7FFA minutes, 0x7FFB hours, 0x7FFC day of week, 0x7FFD day of month, 0x7FFE month, 0x7FFF year. A read (cs=1, we=0) returns the addressed shadow byte in the same cycle. Other addresses read 0x00. When control bits 7 and 6 are both 0, the time shadows copy the counters one cycle after each pulse.
- R6: While control bit 6 (read-hold) is 1, the time shadows do not change, but the counters keep counting. After the bit is cleared, the next pulse shows every second that has elapsed.
- R7: While control bit 7 (set) is 1, refresh stops and the time shadows hold the values written to them. Clearing bit 7 loads the counters from the shadows two cycles after that write, and later pulses count on from the loaded time.
- R8: Control bits 5:0 are stored and read back unchanged, and have no effect on counting.
- R9: After reset the bytes read control 0x00, 00:00:00, day of week 01, day of month 01, month 01, year 00.
- R10: A write to an address outside 0x7FF8..0x7FFF changes no byte of the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| cs | input | 1 | Bus access strobe |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (15) | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from the addressed shadow byte |

## Verification
The bench targets the following rollover corners:
- 59-second and 59-minute carries.
- Midnight, with day of week going from 7 to 1.
- The end of a 30-day month.
- February in a leap year and in a common year.
- 31 December in an ordinary year and in year 99.

A design with a wrong month table or leap rule would show 29 or 31 where 01 is expected, or would skip the leap day.

The bench also checks the following access behaviour:
- The read-hold freeze. A design that stopped the counters instead of only the shadows would come back short of the elapsed seconds.
- The set-and-load sequence. A design that never loaded, or loaded at the wrong moment, would count on from the old time.
- The calibration field, the reset image and out-of-window writes. Each of these would show up as a wrong byte in the window.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int NBYTES = 8;
    localparam int OFF_W  = $clog2(NBYTES);
    localparam int NTIME  = NBYTES - 1;

    typedef struct packed {
        logic [7:0] year;
        logic [7:0] month;
        logic [7:0] mday;
        logic [7:0] wday;
        logic [7:0] hours;
        logic [7:0] mins;
        logic [7:0] secs;
    } cal_t;

    typedef logic [NBYTES-1:0][7:0] bank_t;
    typedef logic [NTIME-1:0][7:0]  tbytes_t;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_LOAD  = 2'd3
    } acc_state_e;

    localparam cal_t CAL_RESET = '{year: 8'h00, month: 8'h01, mday: 8'h01,
                                   wday: 8'h01, hours: 8'h00, mins: 8'h00,
                                   secs: 8'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'h0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic bcd_leap(input logic [7:0] y);
        logic u0, u1;
        u0 = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        u1 = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        return y[4] ? u1 : u0;
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
        if (m == 8'h02)
            return bcd_leap(y) ? 8'h29 : 8'h28;
        else if (m == 8'h04 || m == 8'h06 || m == 8'h09 || m == 8'h11)
            return 8'h30;
        else
            return 8'h31;
    endfunction

    function automatic tbytes_t cal_to_tbytes(input cal_t c);
        tbytes_t t;
        t[0] = c.secs;
        t[1] = c.mins;
        t[2] = c.hours;
        t[3] = c.wday;
        t[4] = c.mday;
        t[5] = c.month;
        t[6] = c.year;
        return t;
    endfunction

    function automatic cal_t tbytes_to_cal(input tbytes_t t);
        cal_t c;
        c.secs  = t[0];
        c.mins  = t[1];
        c.hours = t[2];
        c.wday  = t[3];
        c.mday  = t[4];
        c.month = t[5];
        c.year  = t[6];
        return c;
    endfunction

    localparam tbytes_t TIME_RESET = cal_to_tbytes(CAL_RESET);

endpackage

// File: rtl/rtc_counters.sv
module rtc_counters
    import rtc_cal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic load,
    input  cal_t load_val,
    output cal_t cnt
);

    cal_t nxt;
    logic sec_wrap, min_wrap, day_wrap, mon_wrap, yr_wrap;

    always_comb begin
        sec_wrap = (cnt.secs == 8'h59);
        min_wrap = sec_wrap && (cnt.mins == 8'h59);
        day_wrap = min_wrap && (cnt.hours == 8'h23);
        mon_wrap = day_wrap && (cnt.mday == month_last(cnt.month, cnt.year));
        yr_wrap  = mon_wrap && (cnt.month == 8'h12);

        nxt = cnt;
        nxt.secs = sec_wrap ? 8'h00 : bcd_inc(cnt.secs);
        if (sec_wrap) nxt.mins  = min_wrap ? 8'h00 : bcd_inc(cnt.mins);
        if (min_wrap) nxt.hours = day_wrap ? 8'h00 : bcd_inc(cnt.hours);
        if (day_wrap) begin
            nxt.wday = (cnt.wday == 8'h07) ? 8'h01 : bcd_inc(cnt.wday);
            nxt.mday = mon_wrap ? 8'h01 : bcd_inc(cnt.mday);
        end
        if (mon_wrap) nxt.month = yr_wrap ? 8'h01 : bcd_inc(cnt.month);
        if (yr_wrap)  nxt.year  = (cnt.year == 8'h99) ? 8'h00 : bcd_inc(cnt.year);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= CAL_RESET;
        else if (load) cnt <= load_val;
        else if (tick) cnt <= nxt;
    end

    // R1: minutes move only on a seconds carry
    a_r1_min_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(tick && cnt.secs == 8'h59)) |=> $stable(cnt.mins));

    // R4: the year moves only on the last second of December
    a_r4_year_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(tick && cnt.month == 8'h12 && cnt.mday == 8'h31 &&
                    cnt.hours == 8'h23 && cnt.mins == 8'h59 && cnt.secs == 8'h59))
        |=> $stable(cnt.year));

endmodule

// File: rtl/rtc_access_fsm.sv
module rtc_access_fsm
    import rtc_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       set_bit,
    input  logic       hold_bit,
    output acc_state_e state,
    output logic       refresh,
    output logic       load
);

    acc_state_e st_q, st_d;
    logic       tick_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN:   if (set_bit) st_d = ST_WRITE; else if (hold_bit) st_d = ST_READ;
            ST_READ:  if (set_bit) st_d = ST_WRITE; else if (!hold_bit) st_d = ST_RUN;
            ST_WRITE: if (!set_bit) st_d = ST_LOAD;
            ST_LOAD:  if (set_bit) st_d = ST_WRITE;
                      else if (hold_bit) st_d = ST_READ;
                      else st_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_RUN;
            tick_d <= 1'b0;
        end else begin
            st_q   <= st_d;
            tick_d <= tick;
        end
    end

    always_comb begin
        state   = st_q;
        refresh = 1'b0;
        load    = 1'b0;
        unique case (st_q)
            ST_RUN:   refresh = tick_d;
            ST_READ:  refresh = 1'b0;
            ST_WRITE: refresh = 1'b0;
            ST_LOAD:  load = 1'b1;
        endcase
    end

    // R7: the load state lasts one cycle
    a_r7_load_single: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOAD) |=> (st_q != ST_LOAD));

endmodule

// File: rtl/rtc_shadow_bank.sv
module rtc_shadow_bank
    import rtc_cal_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFF_W-1:0] wr_off,
    input  logic [7:0]       wr_data,
    input  logic             refresh,
    input  cal_t             cnt,
    output bank_t            bank
);

    tbytes_t cnt_tb;
    assign cnt_tb = cal_to_tbytes(cnt);

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        if (i == 0) begin : g_ctrl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bank[i] <= 8'h00;
                else if (wr_en && wr_off == OFF_W'(i))
                    bank[i] <= wr_data;
            end
        end else begin : g_time
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bank[i] <= TIME_RESET[i-1];
                else if (wr_en && wr_off == OFF_W'(i))
                    bank[i] <= wr_data;
                else if (refresh)
                    bank[i] <= cnt_tb[i-1];
            end
        end
    end

endmodule

// File: rtl/rtc_calendar_top.sv
module rtc_calendar_top
    import rtc_cal_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic             in_win, bus_wr, refresh, load;
    logic [OFF_W-1:0] off;
    acc_state_e       state;
    bank_t            bank;
    cal_t             cnt, load_val;

    assign in_win   = &addr[ADDR_W-1:OFF_W];
    assign off      = addr[OFF_W-1:0];
    assign bus_wr   = cs && we && in_win;
    assign load_val = tbytes_to_cal(bank[NBYTES-1:1]);
    assign rdata    = (cs && !we && in_win) ? bank[off] : 8'h00;

    rtc_access_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .set_bit(bank[0][7]), .hold_bit(bank[0][6]),
        .state(state), .refresh(refresh), .load(load)
    );

    rtc_counters u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .load(load), .load_val(load_val), .cnt(cnt)
    );

    rtc_shadow_bank u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_off(off),
        .wr_data(wdata), .refresh(refresh), .cnt(cnt), .bank(bank)
    );

    // R6: the read-hold freeze keeps the time shadows still
    a_r6_read_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_READ && !bus_wr) |=> $stable(bank[NBYTES-1:1]));

    // R7: the set state keeps the time shadows still apart from bus writes
    a_r7_write_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WRITE && !bus_wr) |=> $stable(bank[NBYTES-1:1]));

    // R5: a refresh copies the live seconds count
    a_r5_refresh_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh && !bus_wr) |=> (bank[1] == $past(cnt.secs)));

endmodule

// File: tb/rtc_calendar_top_test.sv
module rtc_calendar_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        cs = 1'b0;
    logic        we = 1'b0;
    logic [14:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;

    int errors = 0;
    int checks = 0;
    logic rd_active = 1'b0;

    logic [14:0] exp_a[$];
    logic [7:0]  exp_d[$];
    string       exp_t[$];

    localparam logic [14:0] A_CTL = 15'h7FF8, A_SEC = 15'h7FF9, A_MIN = 15'h7FFA,
                            A_HR = 15'h7FFB, A_WD = 15'h7FFC, A_MD = 15'h7FFD,
                            A_MON = 15'h7FFE, A_YR = 15'h7FFF;

    always #2 clk = ~clk;

    rtc_calendar_top uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cs(cs), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // monitor: pops the scoreboard on every requested read
    always @(negedge clk) begin
        if (rd_active && cs && !we) begin
            if (exp_a.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: read with no expected item");
            end else begin
                logic [14:0] a; logic [7:0] d; string t;
                a = exp_a.pop_front(); d = exp_d.pop_front(); t = exp_t.pop_front();
                checks++;
                if (rdata !== d || addr !== a) begin
                    errors++;
                    $display("FAIL %s addr=%h actual=%h expected=%h", t, a, rdata, d);
                end
            end
        end
    end

    task automatic chk(input logic [14:0] a, input logic [7:0] e, input string tag);
        @(posedge clk); #1;
        exp_a.push_back(a); exp_d.push_back(e); exp_t.push_back(tag);
        cs = 1'b1; we = 1'b0; addr = a; rd_active = 1'b1;
        @(posedge clk); #1;
        cs = 1'b0; rd_active = 1'b0;
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic pulse();
        @(posedge clk); #1 tick = 1'b1;
        @(posedge clk); #1 tick = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic set_time(input logic [7:0] y, mo, md, wd, h, mi, s);
        wr(A_CTL, 8'h80);
        wr(A_SEC, s); wr(A_MIN, mi); wr(A_HR, h);
        wr(A_WD, wd); wr(A_MD, md); wr(A_MON, mo); wr(A_YR, y);
        wr(A_CTL, 8'h00);
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic chk_time(input string tag, input logic [7:0] y, mo, md, wd, h, mi, s);
        chk(A_SEC, s, tag); chk(A_MIN, mi, tag); chk(A_HR, h, tag);
        chk(A_WD, wd, tag); chk(A_MD, md, tag); chk(A_MON, mo, tag); chk(A_YR, y, tag);
    endtask

    task automatic finish_run();
        if (exp_a.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_a.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9 reset image
        chk(A_CTL, 8'h00, "R9");
        chk_time("R9", 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);

        // R5 refresh after a pulse, out-of-window read
        pulse();
        chk(A_SEC, 8'h01, "R5");
        chk(15'h0000, 8'h00, "R5");

        // R1 seconds carry
        set_time(8'h10, 8'h03, 8'h05, 8'h02, 8'h12, 8'h34, 8'h59);
        pulse();
        chk_time("R1", 8'h10, 8'h03, 8'h05, 8'h02, 8'h12, 8'h35, 8'h00);

        // R1 R2 midnight with weekday 7 to 1
        set_time(8'h21, 8'h06, 8'h15, 8'h07, 8'h23, 8'h59, 8'h59);
        pulse();
        chk_time("R2", 8'h21, 8'h06, 8'h16, 8'h01, 8'h00, 8'h00, 8'h00);

        // R3 30-day month
        set_time(8'h21, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59);
        pulse();
        chk_time("R3", 8'h21, 8'h05, 8'h01, 8'h04, 8'h00, 8'h00, 8'h00);

        // R3 31-day month
        set_time(8'h21, 8'h01, 8'h31, 8'h03, 8'h23, 8'h59, 8'h59);
        pulse();
        chk(A_MD, 8'h01, "R3"); chk(A_MON, 8'h02, "R3");

        // R3 common February
        set_time(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        pulse();
        chk(A_MD, 8'h01, "R3"); chk(A_MON, 8'h03, "R3");

        // R3 leap February: 28 to 29, then 29 to 01 March
        set_time(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59);
        pulse();
        chk(A_MD, 8'h29, "R3"); chk(A_MON, 8'h02, "R3");
        set_time(8'h24, 8'h02, 8'h29, 8'h03, 8'h23, 8'h59, 8'h59);
        pulse();
        chk(A_MD, 8'h01, "R3"); chk(A_MON, 8'h03, "R3");

        // R4 year end, ordinary and 99 wrap
        set_time(8'h45, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        pulse();
        chk_time("R4", 8'h46, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00);
        set_time(8'h99, 8'h12, 8'h31, 8'h05, 8'h23, 8'h59, 8'h59);
        pulse();
        chk_time("R4", 8'h00, 8'h01, 8'h01, 8'h06, 8'h00, 8'h00, 8'h00);

        // R6 read-hold freezes the shadows, counters keep running
        set_time(8'h30, 8'h07, 8'h10, 8'h02, 8'h10, 8'h00, 8'h00);
        wr(A_CTL, 8'h40);
        pulse(); pulse(); pulse();
        chk(A_SEC, 8'h00, "R6");
        wr(A_CTL, 8'h00);
        pulse();
        chk(A_SEC, 8'h04, "R6");

        // R7 set bit: pulses do not refresh, written values held, then loaded
        wr(A_CTL, 8'h80);
        wr(A_MIN, 8'h20);
        pulse();
        chk(A_MIN, 8'h20, "R7");
        chk(A_SEC, 8'h04, "R7");
        wr(A_CTL, 8'h00);
        repeat (3) @(posedge clk);
        #1;
        pulse();
        chk(A_MIN, 8'h20, "R7");
        chk(A_SEC, 8'h05, "R7");

        // R8 calibration field stored, counting unaffected
        wr(A_CTL, 8'h2A);
        chk(A_CTL, 8'h2A, "R8");
        pulse();
        chk(A_SEC, 8'h06, "R8");
        chk(A_CTL, 8'h2A, "R8");
        wr(A_CTL, 8'h00);

        // R10 write outside the window
        wr(15'h7FF0, 8'h55);
        wr(15'h0001, 8'h77);
        chk(A_SEC, 8'h06, "R10");
        chk(A_MIN, 8'h20, "R10");
        chk(A_CTL, 8'h00, "R10");
        chk(15'h7FF0, 8'h00, "R10");

        repeat (4) @(posedge clk);
        finish_run();
    end

endmodule